// File: doc/BRIEF.md
# Table-Driven CRC32 Engine with Register Control

This peripheral folds a stream of 32-bit words into a running 32-bit CRC. Software first writes a generator polynomial in bit-reversed form. That write makes the block build a 256-entry byte lookup table, one entry per clock, and a table-ready status bit reports when the table is finished. Software then seeds the running CRC and loads a count of words to process. A run starts when the run-enable bit is set with the mode field selecting calculation.

Words enter on a valid/ready stream. Each accepted word is folded in one byte per clock, lowest byte first, and the stream stays stalled for those four clocks. When the last counted word has been folded, a sticky completion flag is set, an interrupt is raised if it has been enabled, and the final CRC can be read from the result register. Status flags are cleared by writing one to them. Interrupt enables have separate write-one-to-set and write-one-to-clear addresses.

Top module: `crc_mmio_engine`

## Requirements
- R1: After reset, every readable register returns 0 (the table-ready bit included), in_ready is 0 and irq is 0.
- R2: A write to the polynomial register (address 1) clears status bit 2 (table ready) at the write edge. The bit sets again exactly 256 clock edges later, and in_ready stays 0 until it does.
- R3: Each word is folded lowest byte first. For every bit, lowest first: if crc[0] xor the data bit is 1, then crc = (crc >> 1) xor poly, otherwise crc = crc >> 1. There is no inversion at the start or the end.
- R4: A write to the result register (address 2) loads the running CRC, and a read of address 2 returns it.
- R5: Address 3 holds the number of words still to process (16 bits). It drops by one when each word completes, and in_ready is 0 while it reads 0.
- R6: After a word is accepted, in_ready is 0 for four clocks, one for each byte folded, and the next word can be accepted in the fifth.
- R7: Words are accepted only while control bit 0 (run enable) is 1 and control bits 2:1 (mode) equal 01. Under any other setting, valid words leave the result unchanged.
- R8: Status bit 0 sets when the word that takes the count from 1 to 0 completes. It stays set until it is cleared.
- R9: Address 5 sets interrupt-enable bits by writing ones, address 6 clears them the same way, and a read of address 5 returns them. irq is high while status bit 0 and enable bit 0 are both 1.
- R10: Writing 1 to status bit 0 (address 4) clears it. Writing 0 leaves it unchanged.
- R11: Status bit 1 (compare error) is a stub that always reads 0. It never raises irq, even when its enable bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Data word valid |
| in_data | input | 32 | Data word |
| in_ready | output | 1 | Engine can take a word this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software never writes the polynomial, the seed or the count while a word is still being folded, and never writes the count in the cycle its last word completes. The directed tasks meet this by programming registers only while the engine is idle. They wait for the full four-clock fold before touching any register, and they poll the table-ready bit before enabling a run. in_data is held steady from the time valid is raised until the accepting edge.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_POLY  = 3'd1,
    A_RES   = 3'd2,
    A_CNT   = 3'd3,
    A_STAT  = 3'd4,
    A_IESET = 3'd5,
    A_IECLR = 3'd6
  } reg_addr_e;

  localparam logic [1:0] MODE_CALC = 2'b01;

  // one table entry: shift a byte index through eight reflected steps
  function automatic logic [CRC_W-1:0] tab_entry(input logic [CRC_W-1:0] poly,
                                                 input logic [BYTE_W-1:0] idx);
    logic [CRC_W-1:0] c;
    c = {{(CRC_W-BYTE_W){1'b0}}, idx};
    for (int b = 0; b < BYTE_W; b++)
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    return c;
  endfunction

  // fold one looked-up entry into the running value
  function automatic logic [CRC_W-1:0] byte_fold(input logic [CRC_W-1:0] crc,
                                                 input logic [CRC_W-1:0] tv);
    return (crc >> BYTE_W) ^ tv;
  endfunction

endpackage

// File: rtl/crc_lut_gen.sv
module crc_lut_gen
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poly_wr,
  input  logic [CRC_W-1:0]  poly_in,
  input  logic [BYTE_W-1:0] rd_idx,
  output logic [CRC_W-1:0]  rd_val,
  output logic [CRC_W-1:0]  poly_cur,
  output logic              tbl_ready
);
  localparam int unsigned DEPTH = 1 << BYTE_W;
  localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(DEPTH - 1);

  logic [CRC_W-1:0]  mem [DEPTH];
  logic              gen_on;
  logic [BYTE_W-1:0] gidx;
  logic              gen_last;

  assign gen_last = gen_on && (gidx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_on    <= 1'b0;
      gidx      <= '0;
      poly_cur  <= '0;
      tbl_ready <= 1'b0;
    end else if (poly_wr) begin
      poly_cur  <= poly_in;
      gen_on    <= 1'b1;
      gidx      <= '0;
      tbl_ready <= 1'b0;
    end else if (gen_on) begin
      gidx <= gidx + 1'b1;
      if (gen_last) begin
        gen_on    <= 1'b0;
        tbl_ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (gen_on) mem[gidx] <= tab_entry(poly_cur, gidx);
  end

  assign rd_val = mem[rd_idx];

  // R2
  poly_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poly_wr |=> !tbl_ready);
  // R2
  ready_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_ready) |-> $past(gen_on) && gidx == '0);

endmodule

// File: rtl/crc_word_engine.sv
module crc_word_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned CNT_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              seed_wr,
  input  logic              cnt_wr,
  input  logic [CRC_W-1:0]  wdata,
  input  logic              in_valid,
  input  logic [CRC_W-1:0]  in_data,
  output logic              in_ready,
  output logic [BYTE_W-1:0] tab_idx,
  input  logic [CRC_W-1:0]  tab_val,
  output logic [CRC_W-1:0]  crc,
  output logic [CNT_W-1:0]  cnt,
  output logic              last_done
);
  localparam int unsigned NBYTES = CRC_W / BYTE_W;
  localparam int unsigned BIDX_W = $clog2(NBYTES);
  localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(NBYTES - 1);

  logic              busy;
  logic [BIDX_W-1:0] bidx;
  logic [CRC_W-1:0]  word_q;
  logic [CRC_W-1:0]  word_sh;
  logic              accept;
  logic              word_done;

  assign in_ready  = go && !busy && (cnt != '0);
  assign accept    = in_valid && in_ready;
  assign word_sh   = word_q >> {bidx, 3'b000};
  assign tab_idx   = crc[BYTE_W-1:0] ^ word_sh[BYTE_W-1:0];
  assign word_done = busy && (bidx == BIDX_LAST);
  assign last_done = word_done && (cnt == CNT_W'(1)) && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bidx   <= '0;
      word_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      bidx   <= '0;
      word_q <= in_data;
    end else if (busy) begin
      bidx <= bidx + 1'b1;
      if (word_done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc <= '0;
    else if (seed_wr) crc <= wdata;
    else if (busy)    crc <= byte_fold(crc, tab_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (cnt_wr)    cnt <= wdata[CNT_W-1:0];
    else if (word_done) cnt <= cnt - CNT_W'(1);
  end

  // R6
  stall_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !in_ready);
  // R5
  take_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> cnt != '0);
  // R6
  fold_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bidx == '0) |=> busy);

endmodule

// File: rtl/crc_mmio_engine.sv
module crc_mmio_engine
  import crc_eng_pkg::*;
#(
  parameter int unsigned CNT_W = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        irq
);
  logic [2:0]        ctrl_q;
  logic [1:0]        ien_q;
  logic              expired_q;
  logic              run_en;
  logic [1:0]        mode;
  logic              tbl_ready;
  logic [CRC_W-1:0]  poly_cur;
  logic [BYTE_W-1:0] tab_idx;
  logic [CRC_W-1:0]  tab_val;
  logic [CRC_W-1:0]  crc;
  logic [CNT_W-1:0]  cnt;
  logic              last_done;
  logic              go;
  logic              wr_ctrl, wr_poly, wr_res, wr_cnt, wr_stat, wr_ieset, wr_ieclr;

  assign wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  assign wr_poly  = reg_wr && reg_addr == A_POLY;
  assign wr_res   = reg_wr && reg_addr == A_RES;
  assign wr_cnt   = reg_wr && reg_addr == A_CNT;
  assign wr_stat  = reg_wr && reg_addr == A_STAT;
  assign wr_ieset = reg_wr && reg_addr == A_IESET;
  assign wr_ieclr = reg_wr && reg_addr == A_IECLR;

  assign run_en = ctrl_q[0];
  assign mode   = ctrl_q[2:1];
  assign go     = run_en && (mode == MODE_CALC) && tbl_ready;

  crc_lut_gen u_lut (
    .clk       (clk),
    .rst_n     (rst_n),
    .poly_wr   (wr_poly),
    .poly_in   (reg_wdata),
    .rd_idx    (tab_idx),
    .rd_val    (tab_val),
    .poly_cur  (poly_cur),
    .tbl_ready (tbl_ready)
  );

  crc_word_engine #(.CNT_W(CNT_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .seed_wr   (wr_res),
    .cnt_wr    (wr_cnt),
    .wdata     (reg_wdata),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .tab_idx   (tab_idx),
    .tab_val   (tab_val),
    .crc       (crc),
    .cnt       (cnt),
    .last_done (last_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ien_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q <= reg_wdata[2:0];
      if (wr_ieset) ien_q  <= ien_q | reg_wdata[1:0];
      else if (wr_ieclr) ien_q <= ien_q & ~reg_wdata[1:0];
      if (last_done) expired_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) expired_q <= 1'b0;
    end
  end

  // compare-error status is a stub bit: always zero
  assign irq = expired_q && ien_q[0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = {29'd0, ctrl_q};
      A_POLY:  reg_rdata = poly_cur;
      A_RES:   reg_rdata = crc;
      A_CNT:   reg_rdata = 32'(cnt);
      A_STAT:  reg_rdata = {29'd0, tbl_ready, 1'b0, expired_q};
      A_IESET: reg_rdata = {30'd0, ien_q};
      A_IECLR: reg_rdata = {30'd0, ien_q};
      default: reg_rdata = '0;
    endcase
  end

  // R7
  gate_by_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tbl_ready && ctrl_q[0] && ctrl_q[2:1] == MODE_CALC);
  // R8
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_q) |-> cnt == '0);
  // R9
  irq_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_done && ien_q[0] && !wr_ieclr) |=> irq);
  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !wr_stat) |=> expired_q);

endmodule

// File: tb/crc_mmio_engine_test.sv
`timescale 1ns/1ps
module crc_mmio_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  crc_mmio_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ref_word(input logic [31:0] c0, input logic [31:0] w,
                                           input logic [31:0] poly);
    logic [31:0] c;
    c = c0;
    for (int i = 0; i < 32; i++) begin
      if (c[0] ^ w[i]) c = (c >> 1) ^ poly;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // ends at the negedge just after the accepting edge
  task automatic push(input logic [31:0] w);
    int guard;
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    guard = 0;
    while (!in_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_table();
    logic [31:0] s;
    int guard;
    guard = 0;
    rd(3'd4, s);
    while (!s[2] && guard < 1000) begin
      @(negedge clk);
      rd(3'd4, s);
      guard++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 7; a++) begin
      rd(a[2:0], v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 in_ready reset", {31'd0, in_ready}, 32'h0);
    chk("R1 irq reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_table(input logic [31:0] poly);
    logic [31:0] s;
    wr(3'd1, poly);
    rd(3'd4, s);
    chk("R2 table bit clear after poly write", {31'd0, s[2]}, 32'h0);
    repeat (255) @(negedge clk);
    rd(3'd4, s);
    chk("R2 table bit still clear at 255", {31'd0, s[2]}, 32'h0);
    chk("R2 ready low during build", {31'd0, in_ready}, 32'h0);
    @(negedge clk);
    rd(3'd4, s);
    chk("R2 table bit set at 256", {31'd0, s[2]}, 32'h1);
    rd(3'd1, s);
    chk("R2 poly readback", s, poly);
  endtask

  task automatic t_mode_gate();
    logic [31:0] v;
    wr(3'd2, 32'h1357_9BDF);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h1);
    wr(3'd4, 32'h1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7 ready low with mode 00", {31'd0, in_ready}, 32'h0);
    end
    in_valid = 1'b0;
    rd(3'd2, v);
    chk("R7 result untouched", v, 32'h1357_9BDF);
    rd(3'd3, v);
    chk("R7 count untouched", v, 32'd2);
    wr(3'd0, 32'h5);
    chk("R7 ready low with mode 10", {31'd0, in_ready}, 32'h0);
    wr(3'd0, 32'h3);
    chk("R7 ready high with calc mode", {31'd0, in_ready}, 32'h1);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_stream(input logic [31:0] poly, input logic [31:0] seed,
                          input int n, input logic [31:0] base);
    logic [31:0] exp_crc, w, v;
    exp_crc = seed;
    wr(3'd5, 32'h1);
    wr(3'd3, 32'(n));
    wr(3'd2, seed);
    wr(3'd0, 32'h3);
    for (int k = 0; k < n; k++) begin
      w = base ^ (32'h9E37_79B9 * 32'(k + 1));
      exp_crc = ref_word(exp_crc, w, poly);
      push(w);
      chk("R6 ready low after take", {31'd0, in_ready}, 32'h0);
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk("R6 ready low while folding", {31'd0, in_ready}, 32'h0);
      end
      @(negedge clk);
      rd(3'd3, v);
      chk("R5 count decrement", v, 32'(n - 1 - k));
      chk("R6 ready back after fold", {31'd0, in_ready}, (k == n - 1) ? 32'h0 : 32'h1);
      rd(3'd4, v);
      chk("R8 done flag", {31'd0, v[0]}, (k == n - 1) ? 32'h1 : 32'h0);
      chk("R9 irq", {31'd0, irq}, (k == n - 1) ? 32'h1 : 32'h0);
      rd(3'd2, v);
      chk("R3 running crc", v, exp_crc);
    end
    repeat (3) @(negedge clk);
    rd(3'd4, v);
    chk("R8 flag sticky", {31'd0, v[0]}, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd4, v);
    chk("R10 zero write keeps flag", {31'd0, v[0]}, 32'h1);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
    chk("R10 one write clears flag", {31'd0, v[0]}, 32'h0);
    chk("R9 irq drops with flag", {31'd0, irq}, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd2, 32'hCAFE_F00D);
    rd(3'd2, v);
    chk("R4 seed readback", v, 32'hCAFE_F00D);
    wr(3'd5, 32'h3);
    rd(3'd5, v);
    chk("R9 enable set", v, 32'h3);
    wr(3'd4, 32'h2);
    rd(3'd4, v);
    chk("R11 compare bit reads zero", {31'd0, v[1]}, 32'h0);
    chk("R11 no irq from stub", {31'd0, irq}, 32'h0);
    wr(3'd6, 32'h1);
    rd(3'd5, v);
    chk("R9 enable clear", v, 32'h2);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h3);
    chk("R5 ready low at zero count", {31'd0, in_ready}, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table(32'hEDB8_8320);
    t_mode_gate();
    t_stream(32'hEDB8_8320, 32'hFFFF_FFFF, 3, 32'h1234_5678);
    t_regs();
    wr(3'd1, 32'h82F6_3B78);
    wait_table();
    t_stream(32'h82F6_3B78, 32'h0000_0000, 2, 32'hA5A5_0F0F);
    t_stream(32'h82F6_3B78, 32'h89AB_CDEF, 1, 32'h0000_0000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule